// File: doc/BRIEF.md
# Interrupt Status, Mask and Completion Tally Bank

This block holds the interrupt state of one DMA channel. Eight event inputs each arrive as single-cycle pulses. Each pulse sets a sticky status flag that stays set until software clears it by writing a one to it. A mask holds a one for every source that may not raise the interrupt line. Software never writes the mask directly. It uses two write-only command words instead: one clears mask bits and the other sets them.

A small wrap-around tally counts completed transfers. It counts up on every completion pulse. It counts down when software acknowledges a pending completion flag. Software can also zero any of its bits by writing ones to them.

The interrupt line is the OR of all pending flags whose mask bit is clear. Software reaches every register through a single-cycle write strobe and a combinational read, each addressed by word index.

Top module: `evt_irq_bank`

## Requirements
- R1: After a synchronous active-low reset, every status flag reads 0, the mask reads 0xFF (all sources masked), the tally reads 0 and the interrupt line is low.
- R2: An event pulse on input bit i sets status flag i. The flag stays set in later cycles until a write clears it.
- R3: A write to word 1 clears each status flag whose data bit is 1 and leaves flags whose data bit is 0 unchanged. If an event pulse for a flag arrives in the same cycle as its clear, the flag stays set.
- R4: A write to word 2 clears every mask bit whose data bit is 1 and leaves the others unchanged. Word 2 always reads as zero.
- R5: A write to word 3 sets every mask bit whose data bit is 1 and leaves the others unchanged. Word 3 always reads as zero.
- R6: The mask reads back at word 4, bits 7:0. A write to word 4 leaves the mask unchanged.
- R7: The interrupt line is high exactly when some status flag is set and its mask bit is 0. It reflects each update from the cycle after the clock edge that applied it.
- R8: The 3-bit tally reads at bits 15:13 of word 0. It adds one for each pulse on event bit 1 (the transfer-done source) and wraps from 7 to 0.
- R9: The tally subtracts one, wrapping from 0 to 7, when a word-1 write has data bit 1 set while status flag 1 is set. The same write while flag 1 is clear leaves the tally unchanged.
- R10: If a done pulse and a word-1 write clearing a set flag 1 happen in the same cycle, the tally is unchanged and flag 1 stays set.
- R11: A write to word 0 clears each tally bit whose data bit in 15:13 is 1. A done pulse in the same cycle adds one to the cleared value. All other bits of word 0 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_i | input | 8 | Event pulses. Bit 7: FIFO overflow, 6: invalid register access, 5: threshold hit, 4: memory timeout, 3: stream timeout, 2: bus response error, 1: transfer done, 0: memory-side done |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 3 | Word index for read and write |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data for reg_addr |
| irq_o | output | 1 | Interrupt line |

## Verification
The bench builds the block with its default parameters: eight sources and a 3-bit tally at bit 13. With these values, a run of eight done pulses brings the tally back to its start value, and acknowledging an empty tally drives it from 0 to 7. Both wrap directions are therefore reachable within a few cycles. The randomised phase applies event pulses, clears and mask commands in the same cycles, so that set-versus-clear collisions on each flag and on the tally occur often.

// File: rtl/irq_bank_pkg.sv
// Shared word indices and source positions for the interrupt register bank.
// Assumes word-indexed register access with a 3-bit index.
package irq_bank_pkg;
    localparam int unsigned ADDR_W = 3;

    localparam logic [ADDR_W-1:0] WORD_TALLY   = 3'd0;
    localparam logic [ADDR_W-1:0] WORD_FLAGS   = 3'd1;
    localparam logic [ADDR_W-1:0] WORD_UNMASK  = 3'd2;
    localparam logic [ADDR_W-1:0] WORD_MASKSET = 3'd3;
    localparam logic [ADDR_W-1:0] WORD_MASK    = 3'd4;

    // source positions; the done source drives the tally
    localparam int unsigned SRC_MEM_DONE  = 0;
    localparam int unsigned SRC_XFER_DONE = 1;
    localparam int unsigned SRC_BUS_ERR   = 2;
    localparam int unsigned SRC_STRM_TMO  = 3;
    localparam int unsigned SRC_MEM_TMO   = 4;
    localparam int unsigned SRC_THRESH    = 5;
    localparam int unsigned SRC_BAD_ACC   = 6;
    localparam int unsigned SRC_FIFO_OVF  = 7;
endpackage

// File: rtl/irq_flag_cell.sv
// One sticky interrupt flag: set by an event pulse, cleared by a write of one.
// Assumes set_i and clr_i are single-cycle; set has priority over clear.
module irq_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    logic flag_q;

    // hold, set or clear the flag
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (set_i)
            flag_q <= 1'b1;
        else if (clr_i)
            flag_q <= 1'b0;
    end

    assign flag_o = flag_q;

    assert_flag_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);
    assert_flag_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_o);
    assert_flag_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr_i) |=> flag_o);
endmodule

// File: rtl/irq_mask_bank.sv
// Interrupt mask updated only through unmask and mask-set command strobes.
// Assumes at most one command strobe per cycle; resets to all ones.
module irq_mask_bank #(
    parameter int unsigned NUM_SRC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               unmask_we,
    input  logic               maskset_we,
    input  logic [NUM_SRC-1:0] sel_bits,
    output logic [NUM_SRC-1:0] mask_o
);
    logic [NUM_SRC-1:0] mask_q;

    // apply unmask or mask-set command to the selected bits
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '1;
        else if (unmask_we)
            mask_q <= mask_q & ~sel_bits;
        else if (maskset_we)
            mask_q <= mask_q | sel_bits;
    end

    assign mask_o = mask_q;

    assert_mask_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (mask_o == {NUM_SRC{1'b1}}));
    assert_unmask_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        unmask_we |=> ((mask_o & $past(sel_bits)) == '0));
    assert_maskset_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (maskset_we && !unmask_we) |=> ((mask_o & $past(sel_bits)) == $past(sel_bits)));
    assert_mask_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!unmask_we && !maskset_we) |=> $stable(mask_o));
endmodule

// File: rtl/done_tally.sv
// Wrap-around completion counter: up on done, down on acknowledge, bitwise W1C.
// Assumes the counter clear is applied before the same-cycle step.
module done_tally #(
    parameter int unsigned CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    input  logic             dec_i,
    input  logic [CNT_W-1:0] clr_bits_i,
    output logic [CNT_W-1:0] cnt_o
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] base;
    logic [CNT_W-1:0] cnt_d;

    // clear selected bits first, then step by the net of inc and dec
    always_comb begin
        base = cnt_q & ~clr_bits_i;
        if (inc_i && !dec_i)
            cnt_d = base + CNT_W'(1);
        else if (dec_i && !inc_i)
            cnt_d = base - CNT_W'(1);
        else
            cnt_d = base;
    end

    // register the next count
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

    assert_tally_up_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !dec_i && clr_bits_i == '0) |=> (cnt_o == $past(cnt_o) + CNT_W'(1)));
    assert_tally_down_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_i && !inc_i && clr_bits_i == '0) |=> (cnt_o == $past(cnt_o) - CNT_W'(1)));
    assert_tally_cancel_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && dec_i && clr_bits_i == '0) |=> $stable(cnt_o));
endmodule

// File: rtl/evt_irq_bank.sv
// Interrupt register bank: sticky flags, command-driven mask, completion tally,
// word-indexed write strobe with combinational read, and one interrupt line.
// Assumes event inputs are single-cycle pulses synchronous to clk.
module evt_irq_bank
    import irq_bank_pkg::*;
#(
    parameter int unsigned NUM_SRC  = 8,
    parameter int unsigned CNT_W    = 3,
    parameter int unsigned CNT_LSB  = 13,
    parameter int unsigned DONE_IDX = SRC_XFER_DONE,
    parameter int unsigned DATA_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        evt_i,
    input  logic              wr_en,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       wr_data,
    output logic [31:0]       rd_data,
    output logic              irq_o
);
    localparam int unsigned CNT_MSB = CNT_LSB + CNT_W - 1;

    logic [NUM_SRC-1:0] flags;
    logic [NUM_SRC-1:0] mask;
    logic [CNT_W-1:0]   tally;
    logic               we_flags;
    logic               we_unmask;
    logic               we_maskset;
    logic               we_tally;
    logic               ack_done;
    logic [CNT_W-1:0]   tally_clr;
    logic               unused_wr_bits;

    // decode the write strobe by word index
    always_comb begin
        we_flags   = wr_en && (reg_addr == WORD_FLAGS);
        we_unmask  = wr_en && (reg_addr == WORD_UNMASK);
        we_maskset = wr_en && (reg_addr == WORD_MASKSET);
        we_tally   = wr_en && (reg_addr == WORD_TALLY);
    end

    genvar gi;
    generate
        for (gi = 0; gi < NUM_SRC; gi++) begin : g_flag
            irq_flag_cell u_cell (
                .clk    (clk),
                .rst_n  (rst_n),
                .set_i  (evt_i[gi]),
                .clr_i  (we_flags && wr_data[gi]),
                .flag_o (flags[gi])
            );
        end
    endgenerate

    irq_mask_bank #(.NUM_SRC(NUM_SRC)) u_mask (
        .clk        (clk),
        .rst_n      (rst_n),
        .unmask_we  (we_unmask),
        .maskset_we (we_maskset),
        .sel_bits   (wr_data[NUM_SRC-1:0]),
        .mask_o     (mask)
    );

    // acknowledge of a pending done flag and the tally clear selection
    always_comb begin
        ack_done  = we_flags && wr_data[DONE_IDX] && flags[DONE_IDX];
        tally_clr = we_tally ? wr_data[CNT_MSB:CNT_LSB] : '0;
    end

    done_tally #(.CNT_W(CNT_W)) u_tally (
        .clk        (clk),
        .rst_n      (rst_n),
        .inc_i      (evt_i[DONE_IDX]),
        .dec_i      (ack_done),
        .clr_bits_i (tally_clr),
        .cnt_o      (tally)
    );

    assign unused_wr_bits = &{1'b0, wr_data};

    // combinational read mux
    always_comb begin
        rd_data = '0;
        case (reg_addr)
            WORD_TALLY: rd_data[CNT_MSB:CNT_LSB] = tally;
            WORD_FLAGS: rd_data[NUM_SRC-1:0]     = flags;
            WORD_MASK:  rd_data[NUM_SRC-1:0]     = mask;
            default:    rd_data = '0;
        endcase
    end

    // interrupt line from pending unmasked flags
    assign irq_o = |(flags & ~mask);

    assert_irq_quiet_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == {NUM_SRC{1'b1}}) |-> !irq_o);
    assert_irq_needs_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (flags != '0));
    assert_mask_word_ro_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_addr == WORD_MASK) |=> $stable(mask));
    assert_done_sticks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i[DONE_IDX] && ack_done) |=> flags[DONE_IDX]);
endmodule

// File: tb/evt_irq_bank_test.sv
// Self-checking bench: directed corner cases plus seeded random traffic
// compared against a bench-side reference model.
module evt_irq_bank_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  evt_i = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        irq_o;

    int unsigned n_chk = 0;
    int unsigned n_bad = 0;
    int unsigned cycles = 0;

    logic [7:0] m_flags = '0;
    logic [7:0] m_mask  = 8'hFF;
    logic [2:0] m_cnt   = '0;

    evt_irq_bank uut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .wr_en(wr_en),
        .reg_addr(reg_addr), .wr_data(wr_data), .rd_data(rd_data), .irq_o(irq_o)
    );

    always #5 clk = ~clk;

    // watchdog
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            n_chk = n_chk + 1;
            n_bad = n_bad + 1;
            $display("FAIL watchdog: cycles=%0d expected < 100000", cycles);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    function automatic logic [7:0] nx_flags(logic [7:0] f, logic [7:0] e, logic w,
                                           logic [2:0] a, logic [31:0] d);
        logic [7:0] c = (w && a == 3'd1) ? d[7:0] : 8'h00;
        return (f & ~c) | e;
    endfunction

    function automatic logic [7:0] nx_mask(logic [7:0] m, logic w, logic [2:0] a,
                                          logic [31:0] d);
        if (w && a == 3'd2) return m & ~d[7:0];
        if (w && a == 3'd3) return m | d[7:0];
        return m;
    endfunction

    function automatic logic [2:0] nx_cnt(logic [2:0] c, logic [7:0] f, logic [7:0] e,
                                         logic w, logic [2:0] a, logic [31:0] d);
        logic       ack = w && a == 3'd1 && d[1] && f[1];
        logic [2:0] b   = (w && a == 3'd0) ? (c & ~d[15:13]) : c;
        if (e[1] && !ack) return b + 3'd1;
        if (ack && !e[1]) return b - 3'd1;
        return b;
    endfunction

    function automatic logic [31:0] exp_rd(logic [2:0] a);
        logic [31:0] r = '0;
        if (a == 3'd0) r[15:13] = m_cnt;
        else if (a == 3'd1) r[7:0] = m_flags;
        else if (a == 3'd4) r[7:0] = m_mask;
        return r;
    endfunction

    task automatic step(input logic [7:0] e, input logic w, input logic [2:0] a,
                        input logic [31:0] d);
        @(negedge clk);
        evt_i = e; wr_en = w; reg_addr = a; wr_data = d;
        @(posedge clk);
        m_cnt   = nx_cnt(m_cnt, m_flags, e, w, a, d);
        m_flags = nx_flags(m_flags, e, w, a, d);
        m_mask  = nx_mask(m_mask, w, a, d);
    endtask

    task automatic chk(input logic [2:0] a, input string tag);
        logic [31:0] ex;
        logic        ei;
        @(negedge clk);
        evt_i = '0; wr_en = 1'b0; reg_addr = a; wr_data = '0;
        #1;
        ex = exp_rd(a);
        ei = |(m_flags & ~m_mask);
        n_chk = n_chk + 1;
        if (rd_data !== ex || irq_o !== ei) begin
            n_bad = n_bad + 1;
            $display("FAIL %s word %0d: rd_data=%h irq=%b expected rd_data=%h irq=%b",
                     tag, a, rd_data, irq_o, ex, ei);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1 reset state
        chk(3'd0, "R1"); chk(3'd1, "R1"); chk(3'd4, "R1");
        // R4 R5 command words read zero
        chk(3'd2, "R4"); chk(3'd3, "R5");
        // R2 event sets a masked flag, R7 no interrupt while masked
        step(8'h20, 1'b0, 3'd0, 0); chk(3'd1, "R2");
        step(8'h00, 1'b0, 3'd0, 0); chk(3'd1, "R2 sticky");
        // R4 unmask source 5, R7 interrupt rises
        step(8'h00, 1'b1, 3'd2, 32'h20); chk(3'd4, "R4"); chk(3'd2, "R4 reads zero");
        // R6 direct mask write ignored
        step(8'h00, 1'b1, 3'd4, 32'h00); chk(3'd4, "R6");
        // R3 clear only selected flags
        step(8'h80, 1'b0, 3'd0, 0);
        step(8'h00, 1'b1, 3'd1, 32'h20); chk(3'd1, "R3"); chk(3'd4, "R7");
        // R3 event wins over same-cycle clear
        step(8'h40, 1'b1, 3'd1, 32'h40); chk(3'd1, "R3 collide");
        // R5 mask-set command
        step(8'h00, 1'b1, 3'd2, 32'hC0); chk(3'd4, "R7 unmasked");
        step(8'h00, 1'b1, 3'd3, 32'h80); chk(3'd4, "R5"); chk(3'd3, "R5 reads zero");
        // R8 three completions
        for (int i = 0; i < 3; i++) step(8'h02, 1'b0, 3'd0, 0);
        chk(3'd0, "R8");
        // R9 acknowledge decrements, second ack on clear flag does nothing
        step(8'h00, 1'b1, 3'd1, 32'h02); chk(3'd0, "R9");
        step(8'h00, 1'b1, 3'd1, 32'h02); chk(3'd0, "R9 no flag");
        // R10 done and ack collide
        step(8'h02, 1'b0, 3'd0, 0);
        step(8'h02, 1'b1, 3'd1, 32'h02); chk(3'd0, "R10"); chk(3'd1, "R10 flag");
        // R8 wrap after eight completions
        for (int i = 0; i < 8; i++) step(8'h02, 1'b0, 3'd0, 0);
        chk(3'd0, "R8 wrap");
        // R11 bitwise clear with same-cycle completion
        step(8'h02, 1'b1, 3'd0, 32'h0000_A000); chk(3'd0, "R11");
        step(8'h00, 1'b1, 3'd0, 32'hFFFF_1FFF); chk(3'd0, "R11 other bits");
        // R9 down-wrap from zero
        step(8'h00, 1'b1, 3'd0, 32'h0000_E000);
        step(8'h02, 1'b0, 3'd0, 0);
        step(8'h00, 1'b1, 3'd0, 32'h0000_2000); chk(3'd0, "R9 prep");
        step(8'h00, 1'b1, 3'd1, 32'h02); chk(3'd0, "R9 wrap");
        // random traffic
        for (int i = 0; i < 3000; i++) begin
            logic [7:0]  e = ($urandom % 4 == 0) ? 8'($urandom) : 8'h00;
            logic        w = ($urandom % 2) == 1;
            logic [2:0]  a = 3'($urandom % 6);
            logic [31:0] d = $urandom;
            step(e, w, a, d);
            chk(3'($urandom % 5), "R7 random");
        end
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule